// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory for a small set of memory blocks shared by up to four caching nodes. For every block it holds a directory state (Uncached, Shared or Dirty), a bit vector naming the nodes that hold a copy (for a Dirty block, the single owner), and the memory copy of the data. Nodes send read-miss and write-miss (read-to-update) requests. The directory answers with a data reply that grants either shared or exclusive permission.

When a write hits a block that other nodes share, the controller sends one invalidation message to those sharers. It then counts their acknowledgements down to zero before it grants exclusive ownership. When a block is Dirty at another node, the controller sends a recall to that owner and waits for the owner's data. It updates memory with that data, then replies. A read of a Dirty block leaves both the old owner and the requester as sharers. A write moves ownership to the requester.

Only one invalidate or recall transaction can be outstanding at a time. Any request that arrives while that transaction is pending is answered with a retry (NACK).

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is Uncached with no sharers and memory data 0. Every output valid is low in the cycles that follow no request and no completing acknowledgement.
- R2: A read of an Uncached block gives, one cycle later, a reply with rsp_excl=0 and the memory data. The block becomes Shared with only the requester.
- R3: A read of a Shared block gives a shared reply (rsp_excl=0) with the memory data, one cycle later. The requester is added to the sharers.
- R4: A write to an Uncached block gives an exclusive reply (rsp_excl=1) one cycle later, and so does a write to a Shared block whose only sharer is the requester. The block becomes Dirty with the requester as owner.
- R5: A write to a Shared block with other sharers produces, one cycle later, a single message with inv_valid=1 and inv_fetch=0. In that message, bit i of inv_mask is set exactly for every sharer i other than the requester. No reply is sent yet.
- R6: A pending counter is loaded with the number of invalidated sharers and drops by one on each ack_valid. One cycle after the acknowledgement that brings it to zero, the requester gets an exclusive reply with the memory data, and the block becomes Dirty owned by the requester alone.
- R7: A request from a node other than the owner of a Dirty block produces a recall message one cycle later. The message has inv_valid=1 and inv_fetch=1, and inv_mask holds only the owner's bit.
- R8: For a recalled read, the acknowledgement's ack_data is written to memory. One cycle later the requester gets a shared reply carrying that data. The block becomes Shared with the old owner and the requester.
- R9: For a recalled write, one cycle after the acknowledgement the requester gets an exclusive reply carrying ack_data. The block becomes Dirty owned by the requester.
- R10: While a transaction is pending, every request gets a NACK one cycle later (nack_valid=1, nack_node = requester). The request leaves no trace in the directory.
- R11: An acknowledgement that arrives while no transaction is pending changes neither memory nor directory state.
- R12: A request from the current owner of a Dirty block gets an exclusive reply with the memory copy one cycle later. The block's state is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_node | input | log2(NODES) | Requesting node |
| req_blk | input | log2(BLOCKS) | Requested block |
| req_wr | input | 1 | 1 = write miss (read-to-update), 0 = read miss |
| ack_valid | input | 1 | Invalidation or recall acknowledgement |
| ack_data | input | DW | Data returned by a recalled owner |
| rsp_valid | output | 1 | Data reply valid |
| rsp_node | output | log2(NODES) | Reply destination |
| rsp_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| rsp_data | output | DW | Block data |
| nack_valid | output | 1 | Retry message valid |
| nack_node | output | log2(NODES) | Retry destination |
| inv_valid | output | 1 | Invalidation or recall message valid |
| inv_mask | output | NODES | Target nodes, bit i = node i |
| inv_blk | output | log2(BLOCKS) | Block being invalidated or recalled |
| inv_fetch | output | 1 | 1 = recall, owner must return data |

## Verification
A wrong sharer vector or state is not visible until a later request touches the same block. It then shows up as a missing or extra bit in inv_mask, a reply in place of an invalidation, or the opposite, one cycle after that request. A wrong pending count shows up as an exclusive reply that comes one acknowledgement too early or too late. Stale memory shows up as wrong rsp_data on the next read after a recall. For these reasons the sequence revisits every block after each transition, and a model compares every output on every cycle.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 4,
  parameter int DW     = 8,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int CW = NW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [NW-1:0]     req_node,
  input  logic [BW-1:0]     req_blk,
  input  logic              req_wr,
  input  logic              ack_valid,
  input  logic [DW-1:0]     ack_data,
  output logic              rsp_valid,
  output logic [NW-1:0]     rsp_node,
  output logic              rsp_excl,
  output logic [DW-1:0]     rsp_data,
  output logic              nack_valid,
  output logic [NW-1:0]     nack_node,
  output logic              inv_valid,
  output logic [NODES-1:0]  inv_mask,
  output logic [BW-1:0]     inv_blk,
  output logic              inv_fetch
);
  typedef enum logic [1:0] {D_UNC = 2'd0, D_SHR = 2'd1, D_DRT = 2'd2} dstate_t;

  dstate_t          st  [BLOCKS];
  logic [NODES-1:0] vec [BLOCKS];
  logic [DW-1:0]    mem [BLOCKS];

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [NW-1:0]    t_node;
  logic [BW-1:0]    t_blk;
  logic             t_wr, t_fetch;

  localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

  logic [NODES-1:0] me, tme, others;
  logic [CW-1:0]    n_others;
  assign me       = ONE << req_node;
  assign tme      = ONE << t_node;
  assign others   = vec[req_blk] & ~me;
  assign n_others = CW'($countones(others));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st[b]  <= D_UNC;
        vec[b] <= '0;
        mem[b] <= '0;
      end
      busy <= 1'b0; cnt <= '0; t_node <= '0; t_blk <= '0; t_wr <= 1'b0; t_fetch <= 1'b0;
      rsp_valid <= 1'b0; rsp_node <= '0; rsp_excl <= 1'b0; rsp_data <= '0;
      nack_valid <= 1'b0; nack_node <= '0;
      inv_valid <= 1'b0; inv_mask <= '0; inv_blk <= '0; inv_fetch <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      nack_valid <= 1'b0;
      inv_valid  <= 1'b0;
      if (busy) begin
        if (req_valid) begin
          nack_valid <= 1'b1;
          nack_node  <= req_node;
        end
        if (ack_valid) begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_node  <= t_node;
            rsp_excl  <= t_wr;
            if (t_fetch) begin
              mem[t_blk] <= ack_data;
              rsp_data   <= ack_data;
            end else begin
              rsp_data <= mem[t_blk];
            end
            if (t_wr) begin
              st[t_blk]  <= D_DRT;
              vec[t_blk] <= tme;
            end else begin
              st[t_blk]  <= D_SHR;
              vec[t_blk] <= vec[t_blk] | tme;
            end
          end
        end
      end else if (req_valid) begin
        rsp_node <= req_node;
        rsp_data <= mem[req_blk];
        t_node   <= req_node;
        t_blk    <= req_blk;
        t_wr     <= req_wr;
        inv_blk  <= req_blk;
        case (st[req_blk])
          D_UNC: begin
            rsp_valid    <= 1'b1;
            rsp_excl     <= req_wr;
            st[req_blk]  <= req_wr ? D_DRT : D_SHR;
            vec[req_blk] <= me;
          end
          D_SHR: begin
            if (!req_wr) begin
              rsp_valid    <= 1'b1;
              rsp_excl     <= 1'b0;
              vec[req_blk] <= vec[req_blk] | me;
            end else if (others == '0) begin
              rsp_valid    <= 1'b1;
              rsp_excl     <= 1'b1;
              st[req_blk]  <= D_DRT;
              vec[req_blk] <= me;
            end else begin
              busy      <= 1'b1;
              cnt       <= n_others;
              t_fetch   <= 1'b0;
              inv_valid <= 1'b1;
              inv_mask  <= others;
              inv_fetch <= 1'b0;
            end
          end
          default: begin
            if (vec[req_blk] == me) begin
              rsp_valid <= 1'b1;
              rsp_excl  <= 1'b1;
            end else begin
              busy      <= 1'b1;
              cnt       <= CW'(1);
              t_fetch   <= 1'b1;
              inv_valid <= 1'b1;
              inv_mask  <= vec[req_blk];
              inv_fetch <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODES = 4,
  parameter int NW    = 2,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [NW-1:0]    req_node,
  input logic             busy,
  input logic [CW-1:0]    cnt,
  input logic             rsp_valid,
  input logic             nack_valid,
  input logic [NW-1:0]    nack_node,
  input logic             inv_valid,
  input logic [NODES-1:0] inv_mask,
  input logic             inv_fetch
);
  AST_IDLE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> (rsp_valid != inv_valid)); // R2
  AST_INV_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !inv_mask[$past(req_node)]); // R5
  AST_INV_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_mask != '0); // R5
  AST_PENDING_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt != '0); // R6
  AST_RECALL_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_fetch |-> $countones(inv_mask) == 1); // R7
  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy |=> nack_valid && nack_node == $past(req_node)); // R10
  AST_NACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nack_valid |-> $past(busy)); // R10
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .NW(NW), .CW(CW)) u_chk (.*);

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req_valid = 0, req_wr = 0, ack_valid = 0;
  logic [1:0] req_node = 0, req_blk = 0;
  logic [7:0] ack_data = 0;
  logic rsp_valid, rsp_excl, nack_valid, inv_valid, inv_fetch;
  logic [1:0] rsp_node, nack_node, inv_blk;
  logic [7:0] rsp_data;
  logic [3:0] inv_mask;

  always #5 clk = ~clk;

  dir_home_ctrl i_dir_home_ctrl (.*);

  int checks = 0, bad = 0, cycles = 0;
  bit done = 0;

  // behavioural model
  int mst [4];          // 0 uncached, 1 shared, 2 dirty
  bit msh [4][4];       // msh[block][node]
  int mmem [4];
  bit mbusy = 0;
  int mcnt = 0, tnode = 0, tblk = 0;
  bit twr = 0, tfetch = 0;

  bit e_rv = 0, e_rx = 0, e_nv = 0, e_iv = 0, e_if = 0;
  int e_rn = 0, e_rd = 0, e_nn = 0, e_ib = 0, e_im = 0;
  string tag = "R1";

  always @(posedge clk) begin
    e_rv = 0; e_nv = 0; e_iv = 0;
    tag = "R1";
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        mst[b] = 0; mmem[b] = 0;
        for (int n = 0; n < 4; n++) msh[b][n] = 0;
      end
      mbusy = 0;
    end else if (mbusy) begin
      if (req_valid) begin e_nv = 1; e_nn = int'(req_node); tag = "R10"; end
      if (ack_valid) begin
        mcnt = mcnt - 1;
        if (mcnt == 0) begin
          mbusy = 0; e_rv = 1; e_rn = tnode; e_rx = twr;
          if (tfetch) mmem[tblk] = int'(ack_data);
          e_rd = mmem[tblk];
          if (twr) begin
            for (int n = 0; n < 4; n++) msh[tblk][n] = (n == tnode);
            mst[tblk] = 2;
            tag = tfetch ? "R9" : "R6";
          end else begin
            msh[tblk][tnode] = 1; mst[tblk] = 1; tag = "R8";
          end
        end
      end
    end else if (req_valid) begin
      int b, r, cnt_other;
      b = int'(req_blk); r = int'(req_node);
      cnt_other = 0;
      for (int n = 0; n < 4; n++) if (msh[b][n] && n != r) cnt_other++;
      e_rn = r; e_rd = mmem[b];
      if (mst[b] == 0 || (mst[b] == 1 && !req_wr) || (mst[b] == 1 && cnt_other == 0)
          || (mst[b] == 2 && cnt_other == 0 && msh[b][r])) begin
        e_rv = 1; e_rx = req_wr || mst[b] == 2;
        if (mst[b] == 2) tag = "R12";
        else if (req_wr) tag = "R4";
        else tag = (mst[b] == 0) ? "R2" : "R3";
        if (mst[b] != 2) begin
          if (req_wr) begin
            for (int n = 0; n < 4; n++) msh[b][n] = 0;
            mst[b] = 2;
          end else mst[b] = 1;
          msh[b][r] = 1;
        end
      end else begin
        e_iv = 1; e_ib = b; e_if = (mst[b] == 2); e_im = 0;
        for (int n = 0; n < 4; n++) if (msh[b][n] && n != r) e_im += (1 << n);
        mbusy = 1; mcnt = e_if ? 1 : cnt_other;
        tnode = r; tblk = b; twr = req_wr; tfetch = e_if;
        tag = e_if ? "R7" : "R5";
      end
    end else if (ack_valid) tag = "R11";
  end

  always @(negedge clk) begin
    if (!done) begin
      bit ok;
      ok = (rsp_valid == e_rv) && (nack_valid == e_nv) && (inv_valid == e_iv);
      if (ok && e_rv) ok = (int'(rsp_node) == e_rn) && (rsp_excl == e_rx) && (int'(rsp_data) == e_rd);
      if (ok && e_nv) ok = (int'(nack_node) == e_nn);
      if (ok && e_iv) ok = (int'(inv_mask) == e_im) && (int'(inv_blk) == e_ib) && (inv_fetch == e_if);
      checks++;
      if (!ok) begin
        bad++;
        $display("FAIL %s t=%0t act rsp=%b/%0d/%b/%h nack=%b/%0d inv=%b/%h/%0d/%b exp rsp=%b/%0d/%b/%h nack=%b/%0d inv=%b/%h/%0d/%b",
          tag, $time, rsp_valid, rsp_node, rsp_excl, rsp_data, nack_valid, nack_node,
          inv_valid, inv_mask, inv_blk, inv_fetch,
          e_rv, e_rn, e_rx, e_rd[7:0], e_nv, e_nn, e_iv, e_im[3:0], e_ib, e_if);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 3000 && !done) begin
      done = 1; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic cyc(bit rv, int nd, int bk, bit wr, bit av, int ad);
    @(negedge clk);
    req_valid = rv; req_node = 2'(nd); req_blk = 2'(bk); req_wr = wr;
    ack_valid = av; ack_data = 8'(ad);
  endtask
  task automatic rd(int nd, int bk); cyc(1, nd, bk, 0, 0, 0); endtask
  task automatic wr(int nd, int bk); cyc(1, nd, bk, 1, 0, 0); endtask
  task automatic ack(int d); cyc(0, 0, 0, 0, 1, d); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();                     // R1 quiet after reset
    rd(0, 1); rd(1, 1); rd(2, 1);       // R2, R3
    wr(0, 1);                           // R5: mask nodes 1,2
    rd(3, 2);                           // R10 nack while pending
    ack(0); idle();                     // first of two acks
    ack(0);                             // R6 completes
    idle();
    wr(0, 1);                           // R12 owner re-request
    rd(3, 1);                           // R7 recall from node 0
    idle(); ack(8'hA5);                 // R8
    idle();
    rd(1, 1);                           // R3 sees A5
    ack(8'h11); idle();                 // R11 stray ack
    rd(2, 1);                           // memory still A5
    wr(2, 2);                           // R4 uncached write
    wr(1, 2);                           // R7 recall from node 2
    ack(8'h3C);                         // R9
    rd(0, 2); ack(8'h77); idle();       // R8 with new data
    rd(1, 2);
    rd(3, 3); wr(3, 3);                 // R4 sole sharer upgrade
    rd(0, 0); rd(1, 0); wr(2, 0);       // R5 two sharers, none is requester
    ack(0);
    cyc(1, 1, 3, 1, 1, 0);              // R6 completion and R10 nack together
    idle();
    rd(1, 0);                           // R7 recall from node 2
    cyc(1, 0, 0, 0, 1, 8'h5E);          // R8 completion with R10 nack
    idle(); wr(3, 0);                   // R5 invalidate nodes 1,2
    ack(0); ack(0); idle();             // R6
    rd(0, 0); ack(8'h99); idle(); idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule